// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, called A and B, through a pair of independent transfer paths. Each path has its own storage register with its own capture strobe, its own source select and its own drive enable. A capture strobe is a slow control signal sampled on the system clock. Its low-to-high transition loads the register from the bus on that side. The source select decides what the opposite bus is driven with: the live value arriving on the other bus, or the content held in the register. Data is never inverted on any path.

Each bus is split into an input, an output value and an output-enable, so no internal tri-state is needed. The drive enable for bus B is active high, and the drive enable for bus A is active low. With both enables in the off state, the two buses are isolated and the registers still capture. Because a register loads the resolved bus value, one live path can be looped back so that a single bus is stored into both registers at once.

The strobe detector per direction is a two-state machine. **STB_SPENT** means the strobe was last seen high, or reset has just ended. **STB_ARMED** means the strobe was last seen low. The transition ARMED→SPENT happens when the strobe is sampled high, and this is the only transition that fires a capture. The transition SPENT→ARMED happens when the strobe is sampled low. Reset forces SPENT.

Top module: `dual_path_xcvr`

## Requirements
- R1: A synchronous active-high reset clears both registers to zero and puts both strobe detectors in STB_SPENT. A strobe that is already high when reset ends does not capture until it has first been seen low.
- R2: `b_oe` follows `drv_b` (active high). While `drv_b` is 0, `b_out` is 0.
- R3: `a_oe` is the inverse of `drv_a_n` (active low). While `drv_a_n` is 1, `a_out` is 0.
- R4: With bus B driven, `src_ab`=0 puts `a_in` on `b_out` in the same cycle, and `src_ab`=1 puts the stored A-side register on `b_out`.
- R5: With bus A driven, `src_ba`=0 puts `b_in` on `a_out` in the same cycle, and `src_ba`=1 puts the stored B-side register on `a_out`.
- R6: The A-side register loads exactly once for each low-to-high change of `cap_ab` seen at a system clock edge. It takes the value at that same edge and holds while the strobe stays high or low.
- R7: The B-side register behaves in the same way with `cap_ba` and bus B.
- R8: Captures take place whatever the selects and drive enables are set to, including with both buses isolated.
- R9: A register loads the resolved pad value. This is the block's own output when that side is driven, and the external input otherwise.
- R10: With B driven live from A and A undriven, strobing both registers stores `a_in` in both. With A driven live from B and B undriven, strobing both stores `b_in` in both.
- R11: With both sides driven and both selects at stored, the two register contents are exchanged onto the buses at the same time.
- R12: All channels are independent and non-inverting; every bit position transfers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cap_ab | input | 1 | Capture strobe of the A-side register (rising transition) |
| cap_ba | input | 1 | Capture strobe of the B-side register (rising transition) |
| src_ab | input | 1 | Source for bus B: 0 live A, 1 stored A |
| src_ba | input | 1 | Source for bus A: 0 live B, 1 stored B |
| drv_b | input | 1 | Drive enable of bus B, active high |
| drv_a_n | input | 1 | Drive enable of bus A, active low |
| a_in | input | WIDTH | Bus A pad input |
| a_out | output | WIDTH | Bus A output value |
| a_oe | output | 1 | Bus A output enable |
| b_in | input | WIDTH | Bus B pad input |
| b_out | output | WIDTH | Bus B output value |
| b_oe | output | 1 | Bus B output enable |

## Verification
A vector table runs through the enable and select combinations with the two registers preloaded with distinct patterns and different live inputs on each bus. This separates the live source from the stored source and shows which side each output comes from. Alternating patterns such as 81/7E and single-bit values expose swapped or inverted bits. Directed sequences capture while the buses are isolated, hold a strobe high while the input changes, and leave a strobe high across reset. They also capture a side that is being driven, which distinguishes the resolved pad value from the raw input, and they run both store-into-both-registers loopbacks.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // Strobe detector state: ARMED once the strobe has been seen low,
    // SPENT after a capture has fired or right after reset.
    typedef enum logic [0:0] {
        STB_ARMED = 1'b0,
        STB_SPENT = 1'b1
    } stb_state_t;

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge
    import xcvr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic fire,
    output logic spent
);

    stb_state_t state_q;
    stb_state_t state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            STB_ARMED: if (strobe)  state_d = STB_SPENT;
            STB_SPENT: if (!strobe) state_d = STB_ARMED;
            default:                state_d = STB_SPENT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= STB_SPENT;
        else     state_q <= state_d;
    end

    // outputs: a capture fires only on the ARMED -> SPENT transition
    always_comb begin
        fire  = 1'b0;
        spent = 1'b0;
        unique case (state_q)
            STB_ARMED: fire  = strobe;
            STB_SPENT: spent = 1'b1;
            default:   spent = 1'b1;
        endcase
    end

endmodule

// File: rtl/capture_reg.sv
module capture_reg #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    localparam logic [WIDTH-1:0] CLEAR = '0;

    always_ff @(posedge clk) begin
        if (rst)       q <= CLEAR;
        else if (load) q <= d;
    end

endmodule

// File: rtl/source_mux.sv
module source_mux #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             use_stored,
    input  logic             drive,
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] stored,
    output logic [WIDTH-1:0] value
);

    // one identical, non-inverting channel per bit
    for (genvar ch = 0; ch < WIDTH; ch++) begin : g_chan
        always_comb begin
            value[ch] = 1'b0;
            if (drive) value[ch] = use_stored ? stored[ch] : live[ch];
        end
    end

endmodule

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_ab,
    input  logic             cap_ba,
    input  logic             src_ab,
    input  logic             src_ba,
    input  logic             drv_b,
    input  logic             drv_a_n,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe
);

    logic             fire_ab, fire_ba;
    logic             held_ab, held_ba;
    logic [WIDTH-1:0] q_ab, q_ba;
    logic [WIDTH-1:0] a_pad, b_pad;

    assign a_oe = ~drv_a_n;
    assign b_oe = drv_b;

    // resolved pad values: own output when driving, external input otherwise
    assign a_pad = a_oe ? a_out : a_in;
    assign b_pad = b_oe ? b_out : b_in;

    strobe_edge u_edge_ab (
        .clk    (clk),
        .rst    (rst),
        .strobe (cap_ab),
        .fire   (fire_ab),
        .spent  (held_ab)
    );

    strobe_edge u_edge_ba (
        .clk    (clk),
        .rst    (rst),
        .strobe (cap_ba),
        .fire   (fire_ba),
        .spent  (held_ba)
    );

    capture_reg #(.WIDTH(WIDTH)) u_reg_ab (
        .clk  (clk),
        .rst  (rst),
        .load (fire_ab),
        .d    (a_pad),
        .q    (q_ab)
    );

    capture_reg #(.WIDTH(WIDTH)) u_reg_ba (
        .clk  (clk),
        .rst  (rst),
        .load (fire_ba),
        .d    (b_pad),
        .q    (q_ba)
    );

    // live paths take the opposite external input, which keeps the
    // split-port model free of combinational loops
    source_mux #(.WIDTH(WIDTH)) u_mux_to_b (
        .use_stored (src_ab),
        .drive      (b_oe),
        .live       (a_in),
        .stored     (q_ab),
        .value      (b_out)
    );

    source_mux #(.WIDTH(WIDTH)) u_mux_to_a (
        .use_stored (src_ba),
        .drive      (a_oe),
        .live       (b_in),
        .stored     (q_ba),
        .value      (a_out)
    );

endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cap_ab,
    input logic             cap_ba,
    input logic             src_ab,
    input logic             src_ba,
    input logic             drv_b,
    input logic             drv_a_n,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] a_out,
    input logic             a_oe,
    input logic [WIDTH-1:0] b_out,
    input logic             b_oe,
    input logic [WIDTH-1:0] a_pad,
    input logic [WIDTH-1:0] b_pad,
    input logic [WIDTH-1:0] q_ab,
    input logic [WIDTH-1:0] q_ba,
    input logic             fire_ab,
    input logic             fire_ba
);

    // R1: the cycle after reset both registers read zero
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (q_ab == '0) && (q_ba == '0));

    // R1: a strobe still high at reset release does not capture
    a_r1_no_fire_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !fire_ab && !fire_ba);

    // R2: bus B quiet while its enable is off
    a_r2_b_quiet: assert property (@(posedge clk) disable iff (rst)
        !drv_b |-> (b_out == '0) && !b_oe);

    // R3: bus A quiet while its active-low enable is high
    a_r3_a_quiet: assert property (@(posedge clk) disable iff (rst)
        drv_a_n |-> (a_out == '0) && !a_oe);

    // R4: live A appears on B
    a_r4_live_to_b: assert property (@(posedge clk) disable iff (rst)
        (drv_b && !src_ab) |-> b_out == a_in);

    // R5: live B appears on A
    a_r5_live_to_a: assert property (@(posedge clk) disable iff (rst)
        (!drv_a_n && !src_ba) |-> a_out == b_in);

    // R6: a capture needs a strobe that was low one sample earlier
    a_r6_fire_edge: assert property (@(posedge clk) disable iff (rst)
        fire_ab |-> cap_ab && !$past(cap_ab));

    // R6: the A-side register loads the resolved pad value or holds
    a_r6_load: assert property (@(posedge clk) disable iff (rst)
        ($past(fire_ab) && !$past(rst)) |-> q_ab == $past(a_pad));
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(fire_ab) && !$past(rst)) |-> $stable(q_ab));

    // R7: same for the B-side register
    a_r7_fire_edge: assert property (@(posedge clk) disable iff (rst)
        fire_ba |-> cap_ba && !$past(cap_ba));
    a_r7_load: assert property (@(posedge clk) disable iff (rst)
        ($past(fire_ba) && !$past(rst)) |-> q_ba == $past(b_pad));
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(fire_ba) && !$past(rst)) |-> $stable(q_ba));

    // R11: stored contents on both buses at once
    a_r11_exchange: assert property (@(posedge clk) disable iff (rst)
        (drv_b && !drv_a_n && src_ab && src_ba) |-> (b_out == q_ab) && (a_out == q_ba));

endmodule

bind dual_path_xcvr xcvr_checker #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cap_ab  (cap_ab),
    .cap_ba  (cap_ba),
    .src_ab  (src_ab),
    .src_ba  (src_ba),
    .drv_b   (drv_b),
    .drv_a_n (drv_a_n),
    .a_in    (a_in),
    .b_in    (b_in),
    .a_out   (a_out),
    .a_oe    (a_oe),
    .b_out   (b_out),
    .b_oe    (b_oe),
    .a_pad   (a_pad),
    .b_pad   (b_pad),
    .q_ab    (q_ab),
    .q_ba    (q_ba),
    .fire_ab (fire_ab),
    .fire_ba (fire_ba)
);

// File: tb/sim_dual_path_xcvr.sv
module sim_dual_path_xcvr;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cap_ab = 1'b0, cap_ba = 1'b0;
    logic       src_ab = 1'b0, src_ba = 1'b0;
    logic       drv_b = 1'b0, drv_a_n = 1'b1;
    logic [7:0] a_in = 8'h00, b_in = 8'h00;
    logic [7:0] a_out, b_out;
    logic       a_oe, b_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dual_path_xcvr #(.WIDTH(8)) u0 (
        .clk(clk), .rst(rst), .cap_ab(cap_ab), .cap_ba(cap_ba),
        .src_ab(src_ab), .src_ba(src_ba), .drv_b(drv_b), .drv_a_n(drv_a_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    // vector: {drv_b, drv_a_n, src_ab, src_ba}, a_in, b_in,
    //         exp a_oe, exp a_out, exp b_oe, exp b_out
    // registers hold A-side 3C and B-side A5 during the walk
    localparam logic [37:0] VEC [8] = '{
        {4'b1100, 8'h11, 8'h22, 1'b0, 8'h00, 1'b1, 8'h11},  // R4 live
        {4'b1110, 8'h11, 8'h22, 1'b0, 8'h00, 1'b1, 8'h3C},  // R4 stored
        {4'b0000, 8'h5A, 8'hC3, 1'b1, 8'hC3, 1'b0, 8'h00},  // R5 live
        {4'b0001, 8'h5A, 8'hC3, 1'b1, 8'hA5, 1'b0, 8'h00},  // R5 stored
        {4'b1011, 8'hFF, 8'h00, 1'b1, 8'hA5, 1'b1, 8'h3C},  // R11 exchange
        {4'b1000, 8'h81, 8'h7E, 1'b1, 8'h7E, 1'b1, 8'h81},  // R12 both live
        {4'b0111, 8'hFF, 8'hFF, 1'b0, 8'h00, 1'b0, 8'h00},  // R2 R3 isolated
        {4'b1001, 8'h01, 8'h80, 1'b1, 8'hA5, 1'b1, 8'h01}   // R12 mixed
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_ctl(input logic eb, input logic ean, input logic sab,
                           input logic sba, input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        drv_b = eb; drv_a_n = ean; src_ab = sab; src_ba = sba;
        a_in = a; b_in = b;
        #1;
    endtask

    task automatic pulse(input logic do_ab, input logic do_ba);
        @(negedge clk);
        cap_ab = do_ab; cap_ba = do_ba;
        @(negedge clk);
        cap_ab = 1'b0; cap_ba = 1'b0;
        @(negedge clk);
    endtask

    // show both registers: both sides driven, both selects stored
    task automatic show_stored(input string tag, input logic [7:0] ea, input logic [7:0] eb);
        set_ctl(1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00);
        chk({tag, " B-side bus shows A register"}, b_out, ea);
        chk({tag, " A-side bus shows B register"}, a_out, eb);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: after reset both registers read zero
        show_stored("R1 reset", 8'h00, 8'h00);
        chk("R1 a_oe on", {7'd0, a_oe}, 8'd1);
        chk("R1 b_oe on", {7'd0, b_oe}, 8'd1);

        // R8: capture while both buses are isolated
        set_ctl(1'b0, 1'b1, 1'b1, 1'b1, 8'h3C, 8'hA5);
        chk("R2 b_out zero while isolated", b_out, 8'h00);
        chk("R3 a_out zero while isolated", a_out, 8'h00);
        chk("R2 b_oe off", {7'd0, b_oe}, 8'd0);
        chk("R3 a_oe off", {7'd0, a_oe}, 8'd0);
        pulse(1'b1, 1'b1);
        show_stored("R8 R6 R7 isolated capture", 8'h3C, 8'hA5);

        // table walk, strobes low throughout
        for (int i = 0; i < 8; i++) begin
            set_ctl(VEC[i][37], VEC[i][36], VEC[i][35], VEC[i][34],
                    VEC[i][33:26], VEC[i][25:18]);
            chk($sformatf("table[%0d] R3/R5 a_oe", i), {7'd0, a_oe}, {7'd0, VEC[i][17]});
            chk($sformatf("table[%0d] R5/R11/R12 a_out", i), a_out, VEC[i][16:9]);
            chk($sformatf("table[%0d] R2/R4 b_oe", i), {7'd0, b_oe}, {7'd0, VEC[i][8]});
            chk($sformatf("table[%0d] R4/R11/R12 b_out", i), b_out, VEC[i][7:0]);
        end
        // R6 R7: no strobe during the walk, registers unchanged
        show_stored("R6 R7 hold without strobe", 8'h3C, 8'hA5);

        // R6: strobe held high loads only once
        set_ctl(1'b0, 1'b1, 1'b0, 1'b0, 8'h4B, 8'h00);
        @(negedge clk);
        cap_ab = 1'b1;
        @(negedge clk);
        a_in = 8'hD2;
        repeat (2) @(negedge clk);
        cap_ab = 1'b0;
        @(negedge clk);
        show_stored("R6 held strobe", 8'h4B, 8'hA5);

        // R9: driven side captures its own output, not the external input
        set_ctl(1'b0, 1'b0, 1'b0, 1'b0, 8'h55, 8'h99);
        pulse(1'b1, 1'b0);
        show_stored("R9 resolved A pad", 8'h99, 8'hA5);
        set_ctl(1'b1, 1'b1, 1'b0, 1'b0, 8'h66, 8'h33);
        pulse(1'b0, 1'b1);
        show_stored("R9 resolved B pad", 8'h99, 8'h66);

        // R10: store A in both registers
        set_ctl(1'b1, 1'b1, 1'b0, 1'b0, 8'h6D, 8'h12);
        pulse(1'b1, 1'b1);
        show_stored("R10 A into both", 8'h6D, 8'h6D);
        // R10: store B in both registers
        set_ctl(1'b0, 1'b0, 1'b0, 1'b0, 8'h0B, 8'hE4);
        pulse(1'b1, 1'b1);
        show_stored("R10 B into both", 8'hE4, 8'hE4);

        // R1: reset mid-run with the A strobe held high across release
        set_ctl(1'b1, 1'b1, 1'b1, 1'b0, 8'h77, 8'h00);
        @(negedge clk);
        rst = 1'b1; cap_ab = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk("R1 R6 no capture from strobe high across reset", b_out, 8'h00);
        cap_ab = 1'b0;
        @(negedge clk);
        pulse(1'b1, 1'b0);
        show_stored("R1 R6 capture after rearm", 8'h77, 8'h00);

        done = 1'b1;
        finish_run();
    end

endmodule